// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block takes a DDR3 memory device from power-stable to ready-for-traffic. It holds the memory reset pin low, releases it, and keeps the clock enable low for the required settling time. It then raises clock enable while holding on-die termination low and writes the four mode registers from values supplied on input ports. It finishes by issuing a long ZQ calibration command. A completion flag rises once both the DLL lock time and the ZQ calibration time have run out.

Every wait is counted in controller clock cycles. The microsecond-scale waits are converted from a clock-period parameter at elaboration time and rounded up. The short command gaps are given directly as cycle-count parameters. A synchronous block reset restarts the whole procedure from the reset-low phase at any point. The command pins carry a NOP in every cycle that is not an explicit command slot. After completion the block keeps sending NOPs, and a controller downstream takes over the bus.

Top module: `ddr3_bringup_seq`

## Requirements
- R1: While `rst` is high, `ddr_rst_n`, `cke`, `odt` and `init_done` are 0 and the command pins show NOP: `cs_n`=0, `ras_n`=`cas_n`=`we_n`=1, `ba`=0, `addr`=0.
- R2: Count the last clock cycle in which `rst` is sampled high as the first cycle. `ddr_rst_n` then stays low for ceil(RST_LOW_US·10^6 / CLK_PS) cycles.
- R3: `cke` is low throughout the reset-low phase and in the cycle in which `ddr_rst_n` rises.
- R4: After `ddr_rst_n` rises, `cke` stays low for ceil(CKE_WAIT_US·10^6 / CLK_PS) − 1 cycles and then rises.
- R5: `odt` is low in every cycle, both before and after `cke` rises.
- R6: Once `cke` is high it stays high until the next block reset. The first mode-register write appears exactly XPR_CYC cycles after `cke` rises, and only NOPs are sent before it.
- R7: Mode-register writes use `cs_n`=`ras_n`=`cas_n`=`we_n`=0 and come in the order MR2, MR3, MR1, MR0. Their `ba` values are 3'b010, 3'b011, 3'b001 and 3'b000, and `addr` carries `mr2_val`, `mr3_val`, `mr1_val` and `mr0_val` respectively.
- R8: Consecutive mode-register writes are issued MRD_CYC cycles apart, and the ZQ calibration command follows MR0 by MOD_CYC cycles.
- R9: The ZQ calibration command is `cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=0, with `addr` bit 10 set, all other `addr` bits 0, and `ba`=0.
- R10: `init_done` first reads 1 in cycle max(t_MR0 + DLLK_CYC, t_ZQ + ZQINIT_CYC), where t_X is the cycle in which command X is shown. It then stays high while the bus carries NOPs.
- R11: Every cycle that is not a command slot shows NOP with `ba`=0 and `addr`=0.
- R12: A block reset at any point, including after completion or in the middle of the mode-register writes, clears `init_done`, `cke` and `ddr_rst_n` in the next cycle. It then reruns the full sequence with the same timings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous block reset, active high |
| mr0_val | input | ROW_W | Payload for mode register 0 |
| mr1_val | input | ROW_W | Payload for mode register 1 |
| mr2_val | input | ROW_W | Payload for mode register 2 |
| mr3_val | input | ROW_W | Payload for mode register 3 |
| ddr_rst_n | output | 1 | Memory reset pin, active low |
| cke | output | 1 | Memory clock enable |
| odt | output | 1 | On-die termination control |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 3 | Bank address |
| addr | output | ROW_W | Address / mode payload |
| init_done | output | 1 | Initialization complete |

## Verification
The full bring-up runs twice with different sets of mode-register payloads. The first set uses small sparse values. The second uses complementary byte patterns (A5A5/5A5A/FF00/00FF), so a swapped register or a wrong bank index shows up as a wrong `addr` on a specific command. Each run measures every phase length and command gap against the cycle counts worked out from the parameters, so an off-by-one in any phase is caught on its own. Reset is applied once after completion and once in the middle of the mode-register writes, which separates a true restart from a partial one.

// File: rtl/ddr3i_pkg.sv
package ddr3i_pkg;

  localparam int BA_W = 3;

  typedef enum logic [3:0] {
    PH_RSTLOW, PH_CKEWAIT, PH_XPR,
    PH_MR2, PH_MR3, PH_MR1, PH_MR0,
    PH_ZQ, PH_WAIT, PH_DONE
  } phase_e;

  typedef enum logic [1:0] {CMD_NOP, CMD_MRS, CMD_ZQCL} cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  // ceil(t_ps / clk_ps)
  function automatic longint ps_to_cyc(longint t_ps, longint clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  // bits needed to hold values 0..v
  function automatic int bits_for(longint v);
    for (int i = 1; i < 62; i++)
      if ((64'sd1 <<< i) > v) return i;
    return 62;
  endfunction

  function automatic pins_t cmd_pins(cmd_e c);
    case (c)
      CMD_MRS:  return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      CMD_ZQCL: return '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};
      default:  return '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
  endfunction

  function automatic logic is_mrs_phase(phase_e p);
    return (p == PH_MR2) || (p == PH_MR3) || (p == PH_MR1) || (p == PH_MR0);
  endfunction

  // bank address that selects the mode register written in phase p
  function automatic logic [BA_W-1:0] mr_bank(phase_e p);
    case (p)
      PH_MR2:  return 3'b010;
      PH_MR3:  return 3'b011;
      PH_MR1:  return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/ddr3i_countdown.sv
module ddr3i_countdown #(
  parameter int           W         = 8,
  parameter logic [W-1:0] RST_VAL   = '0,
  parameter bit           RST_ARMED = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expired
);
  logic [W-1:0] cnt;
  logic         armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= RST_VAL;
      armed <= RST_ARMED;
    end else if (load) begin
      cnt   <= val;
      armed <= 1'b1;
    end else if (cnt != '0) begin
      cnt   <= cnt - 1'b1;
    end
  end

  assign expired = armed && (cnt == '0);
endmodule

// File: rtl/ddr3i_cmd_drive.sv
module ddr3i_cmd_drive
  import ddr3i_pkg::*;
#(
  parameter int ROW_W = 16
) (
  input  cmd_e             cmd,
  input  logic [BA_W-1:0]  ba_in,
  input  logic [ROW_W-1:0] addr_in,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr
);
  pins_t pins;

  always_comb begin
    pins  = cmd_pins(cmd);
    cs_n  = pins.cs_n;
    ras_n = pins.ras_n;
    cas_n = pins.cas_n;
    we_n  = pins.we_n;
    ba    = (cmd == CMD_NOP) ? '0 : ba_in;
    addr  = (cmd == CMD_NOP) ? '0 : addr_in;
  end
endmodule

// File: rtl/ddr3_bringup_seq.sv
module ddr3_bringup_seq
  import ddr3i_pkg::*;
#(
  parameter int CLK_PS      = 20000,
  parameter int RST_LOW_US  = 200,
  parameter int CKE_WAIT_US = 500,
  parameter int XPR_CYC     = 64,
  parameter int MRD_CYC     = 4,
  parameter int MOD_CYC     = 12,
  parameter int DLLK_CYC    = 512,
  parameter int ZQINIT_CYC  = 512,
  parameter int ROW_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] mr0_val,
  input  logic [ROW_W-1:0] mr1_val,
  input  logic [ROW_W-1:0] mr2_val,
  input  logic [ROW_W-1:0] mr3_val,
  output logic             ddr_rst_n,
  output logic             cke,
  output logic             odt,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [2:0]       ba,
  output logic [ROW_W-1:0] addr,
  output logic             init_done
);
  localparam longint N_RST   = ps_to_cyc(longint'(RST_LOW_US) * 1000000, CLK_PS);
  localparam longint N_CKE   = ps_to_cyc(longint'(CKE_WAIT_US) * 1000000, CLK_PS) - 1;
  localparam longint PH_MAX  = (N_RST > N_CKE) ? N_RST : N_CKE;
  localparam int     PH_W    = bits_for((PH_MAX > XPR_CYC) ? PH_MAX : longint'(XPR_CYC));
  localparam int     LG_W    = bits_for((DLLK_CYC > ZQINIT_CYC) ? DLLK_CYC : ZQINIT_CYC);
  localparam logic [ROW_W-1:0] ZQ_ADDR = ROW_W'(1) << 10;

  phase_e           ph, ph_nxt;
  logic             ph_exp, dll_exp, zq_exp;
  logic             fresh, ph_load;
  logic [PH_W-1:0]  ph_val;
  logic             mrs_issue, zq_issue, dll_load;
  cmd_e             cmd;
  logic [BA_W-1:0]  cmd_ba;
  logic [ROW_W-1:0] cmd_addr;
  logic [ROW_W-1:0] mr_tab [4];

  assign mr_tab[0] = mr0_val;
  assign mr_tab[1] = mr1_val;
  assign mr_tab[2] = mr2_val;
  assign mr_tab[3] = mr3_val;

  // cycles a phase lasts, minus one (value loaded into the phase timer)
  function automatic logic [PH_W-1:0] hold_of(phase_e p);
    case (p)
      PH_RSTLOW:                return PH_W'(N_RST - 1);
      PH_CKEWAIT:               return PH_W'(N_CKE - 1);
      PH_XPR:                   return PH_W'(XPR_CYC - 1);
      PH_MR2, PH_MR3, PH_MR1:   return PH_W'(MRD_CYC - 1);
      PH_MR0:                   return PH_W'(MOD_CYC - 1);
      default:                  return '0;
    endcase
  endfunction

  always_comb begin
    ph_nxt = ph;
    case (ph)
      PH_RSTLOW:  if (ph_exp) ph_nxt = PH_CKEWAIT;
      PH_CKEWAIT: if (ph_exp) ph_nxt = PH_XPR;
      PH_XPR:     if (ph_exp) ph_nxt = PH_MR2;
      PH_MR2:     if (ph_exp) ph_nxt = PH_MR3;
      PH_MR3:     if (ph_exp) ph_nxt = PH_MR1;
      PH_MR1:     if (ph_exp) ph_nxt = PH_MR0;
      PH_MR0:     if (ph_exp) ph_nxt = PH_ZQ;
      PH_ZQ:      ph_nxt = PH_WAIT;
      PH_WAIT:    if (dll_exp && zq_exp) ph_nxt = PH_DONE;
      default:    ph_nxt = PH_DONE;
    endcase
  end

  assign ph_load = (ph_nxt != ph);
  assign ph_val  = hold_of(ph_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_RSTLOW;
      fresh <= 1'b0;
    end else begin
      ph    <= ph_nxt;
      fresh <= ph_load;
    end
  end

  // command slots: first cycle of a mode-register phase, and the ZQ phase
  assign mrs_issue = fresh && is_mrs_phase(ph);
  assign zq_issue  = fresh && (ph == PH_ZQ);
  assign dll_load  = mrs_issue && (ph == PH_MR0);

  always_comb begin
    cmd      = CMD_NOP;
    cmd_ba   = '0;
    cmd_addr = '0;
    if (mrs_issue) begin
      cmd      = CMD_MRS;
      cmd_ba   = mr_bank(ph);
      cmd_addr = mr_tab[mr_bank(ph)[1:0]];
    end else if (zq_issue) begin
      cmd      = CMD_ZQCL;
      cmd_addr = ZQ_ADDR;
    end
  end

  ddr3i_countdown #(.W(PH_W), .RST_VAL(PH_W'(N_RST - 1)), .RST_ARMED(1'b1)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .val(ph_val), .expired(ph_exp)
  );

  ddr3i_countdown #(.W(LG_W), .RST_VAL('0), .RST_ARMED(1'b0)) u_dll (
    .clk(clk), .rst(rst), .load(dll_load), .val(LG_W'(DLLK_CYC - 1)), .expired(dll_exp)
  );

  ddr3i_countdown #(.W(LG_W), .RST_VAL('0), .RST_ARMED(1'b0)) u_zq (
    .clk(clk), .rst(rst), .load(zq_issue), .val(LG_W'(ZQINIT_CYC - 1)), .expired(zq_exp)
  );

  ddr3i_cmd_drive #(.ROW_W(ROW_W)) u_drv (
    .cmd(cmd), .ba_in(cmd_ba), .addr_in(cmd_addr),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr)
  );

  assign ddr_rst_n = (ph != PH_RSTLOW);
  assign cke       = (ph != PH_RSTLOW) && (ph != PH_CKEWAIT);
  assign odt       = 1'b0;
  assign init_done = ((ph == PH_WAIT) || (ph == PH_DONE)) && dll_exp && zq_exp;
endmodule

// File: rtl/ddr3i_init_chk.sv
module ddr3i_init_chk (
  input logic       clk,
  input logic       rst,
  input logic       ddr_rst_n,
  input logic       cke,
  input logic       init_done,
  input logic       mrs_issue,
  input logic       zq_issue,
  input logic [2:0] ba
);
  logic [2:0] mrs_cnt;
  logic       seen_zq;

  function automatic logic [2:0] order_ba(logic [2:0] n);
    case (n)
      3'd0:    return 3'b010;
      3'd1:    return 3'b011;
      3'd2:    return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      mrs_cnt <= '0;
      seen_zq <= 1'b0;
    end else begin
      if (mrs_issue && mrs_cnt != 3'd7) mrs_cnt <= mrs_cnt + 3'd1;
      if (zq_issue) seen_zq <= 1'b1;
    end
  end

  p_cke_low_at_rstn_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ddr_rst_n) |-> !cke);

  p_cke_held_r6: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  p_mrs_after_cke_r6: assert property (@(posedge clk) disable iff (rst)
    mrs_issue |-> (cke && ddr_rst_n));

  p_mrs_order_r7: assert property (@(posedge clk) disable iff (rst)
    mrs_issue |-> (ba == order_ba(mrs_cnt)));

  p_mrs_count_r7: assert property (@(posedge clk) disable iff (rst)
    mrs_issue |-> (mrs_cnt < 3'd4));

  p_zq_after_mr0_r9: assert property (@(posedge clk) disable iff (rst)
    zq_issue |-> (mrs_cnt == 3'd4) && !seen_zq);

  p_done_after_zq_r10: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (seen_zq && !zq_issue && !mrs_issue));

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
endmodule

bind ddr3_bringup_seq ddr3i_init_chk u_chk (
  .clk(clk), .rst(rst), .ddr_rst_n(ddr_rst_n), .cke(cke), .init_done(init_done),
  .mrs_issue(mrs_issue), .zq_issue(zq_issue), .ba(ba)
);

// File: tb/sim_ddr3_bringup_seq.sv
`timescale 1ns/1ps
module sim_ddr3_bringup_seq;
  localparam int CLK_PS = 20000;
  localparam int ROW_W  = 16;
  localparam int XPR = 64, MRD = 4, MOD = 12, DLLK = 512, ZQI = 512;
  // 200 us and 500 us in picoseconds, rounded up to whole cycles
  localparam int EXP_RST = (200 * 1000 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int EXP_CKE = (500 * 1000 * 1000 + CLK_PS - 1) / CLK_PS - 1;

  typedef struct packed {
    logic [3:0] pins;   // cs_n ras_n cas_n we_n
    logic [2:0] ba;
    logic [2:0] src;    // 0..3 mode register index, 4 = ZQ
    int         gap;    // cycles since previous command (first: since cke rise)
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{pins: 4'b0000, ba: 3'b010, src: 3'd2, gap: XPR},
    '{pins: 4'b0000, ba: 3'b011, src: 3'd3, gap: MRD},
    '{pins: 4'b0000, ba: 3'b001, src: 3'd1, gap: MRD},
    '{pins: 4'b0000, ba: 3'b000, src: 3'd0, gap: MRD},
    '{pins: 4'b0110, ba: 3'b000, src: 3'd4, gap: MOD}
  };

  logic clk = 0, rst = 1;
  logic [ROW_W-1:0] mr [4];
  logic ddr_rst_n, cke, odt, cs_n, ras_n, cas_n, we_n, init_done;
  logic [2:0] ba;
  logic [ROW_W-1:0] addr;
  int cyc = 0, checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr3_bringup_seq u0 (
    .clk(clk), .rst(rst),
    .mr0_val(mr[0]), .mr1_val(mr[1]), .mr2_val(mr[2]), .mr3_val(mr[3]),
    .ddr_rst_n(ddr_rst_n), .cke(cke), .odt(odt),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .init_done(init_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  function automatic bit is_nop;
    return !cs_n && ras_n && cas_n && we_n && ba == 3'b0 && addr == '0;
  endfunction

  task automatic check_reset_state(input string req);
    chk(!ddr_rst_n && !cke && !odt && !init_done, req, "reset pins {rstn,cke,odt,done}",
        {ddr_rst_n, cke, odt, init_done}, 4'b0000);
    chk(is_nop(), req, "reset command is NOP", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
  endtask

  task automatic run_seq(input logic [ROW_W-1:0] m0, m1, m2, m3);
    int rel, t_rstn, t_cke, prev, t_mr0, t_zq, exp_done;
    bit odt_bad, cke_bad, nop_bad, pre_cke_bad;
    logic [ROW_W-1:0] exp_addr;
    mr[0] = m0; mr[1] = m1; mr[2] = m2; mr[3] = m3;
    rst = 1;
    repeat (3) step();
    check_reset_state("R1");
    rel = cyc;
    rst = 0;
    odt_bad = 0; cke_bad = 0; nop_bad = 0; pre_cke_bad = 0;
    do begin
      step();
      if (!ddr_rst_n && cke) pre_cke_bad = 1;
      if (odt) odt_bad = 1;
      if (!is_nop()) nop_bad = 1;
    end while (!ddr_rst_n);
    t_rstn = cyc;
    chk(t_rstn - rel == EXP_RST, "R2", "reset-low length", t_rstn - rel, EXP_RST);
    chk(!cke && !pre_cke_bad, "R3", "cke low through reset-low and at rise", {pre_cke_bad, cke}, 0);
    do begin
      step();
      if (odt) odt_bad = 1;
      if (!is_nop()) nop_bad = 1;
    end while (!cke);
    t_cke = cyc;
    chk(t_cke - t_rstn == EXP_CKE, "R4", "cke-low wait after reset release", t_cke - t_rstn, EXP_CKE);
    chk(!odt, "R5", "odt low when cke rises", odt, 0);
    prev = t_cke;
    t_mr0 = 0; t_zq = 0;
    for (int i = 0; i < 5; i++) begin
      do begin
        step();
        if (odt) odt_bad = 1;
        if (!cke) cke_bad = 1;
      end while (is_nop());
      chk(cyc - prev == VEC[i].gap, (i == 0) ? "R6" : "R8", $sformatf("gap before command %0d", i),
          cyc - prev, VEC[i].gap);
      chk({cs_n, ras_n, cas_n, we_n} == VEC[i].pins, (i < 4) ? "R7" : "R9",
          $sformatf("pins of command %0d", i), {cs_n, ras_n, cas_n, we_n}, VEC[i].pins);
      chk(ba == VEC[i].ba, (i < 4) ? "R7" : "R9", $sformatf("bank of command %0d", i), ba, VEC[i].ba);
      exp_addr = (VEC[i].src < 3'd4) ? mr[VEC[i].src[1:0]] : ROW_W'(16'h0400);
      chk(addr == exp_addr, (i < 4) ? "R7" : "R9", $sformatf("addr of command %0d", i), addr, exp_addr);
      if (i == 3) t_mr0 = cyc;
      if (i == 4) t_zq = cyc;
      prev = cyc;
    end
    exp_done = (t_mr0 + DLLK > t_zq + ZQI) ? t_mr0 + DLLK : t_zq + ZQI;
    do begin
      step();
      if (odt) odt_bad = 1;
      if (!cke) cke_bad = 1;
      if (!is_nop()) nop_bad = 1;
    end while (!init_done && cyc < exp_done + 10);
    chk(init_done && cyc == exp_done, "R10", "init_done rise cycle", cyc, exp_done);
    repeat (20) begin
      step();
      if (!init_done) cke_bad = 1;
      if (!is_nop()) nop_bad = 1;
    end
    chk(init_done && is_nop(), "R10", "init_done held with NOP bus", {init_done, cs_n, ras_n, cas_n, we_n}, 5'b10111);
    chk(!cke_bad && cke, "R6", "cke stayed high after rising", cke_bad, 0);
    chk(!odt_bad, "R5", "odt low all run", odt_bad, 0);
    chk(!nop_bad, "R11", "NOP outside command slots", nop_bad, 0);
  endtask

  initial begin
    mr[0] = '0; mr[1] = '0; mr[2] = '0; mr[3] = '0;
    run_seq(16'h0520, 16'h0044, 16'h0018, 16'h0004);

    // R12: reset after completion
    rst = 1;
    step();
    check_reset_state("R12");
    rst = 0;
    // R12: reset in the middle of the mode-register writes
    do step(); while (!(cke && !cs_n && !ras_n));
    step();
    rst = 1;
    step();
    chk(!ddr_rst_n && !cke && !init_done, "R12", "mid-sequence reset clears pins",
        {ddr_rst_n, cke, init_done}, 3'b000);
    // restart is exercised in full by the second run
    run_seq(16'hA5A5, 16'h5A5A, 16'hFF00, 16'h00FF);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule